// File: doc/BRIEF.md
# Next-Field Microprogram Sequencer

This block steps through a microprogram held in a control store in which every microword names the address of the word that follows it. It has no micro-program counter and no branch logic. The only decision is made by a zero detector on the successor field of the current word. A nonzero value is the next address. A zero value sends control back to opcode dispatch, where the instruction-register opcode itself is the address.

The low region of the store holds the entry word of each opcode at the address equal to that opcode. Entry 0 is the HALT word, and it points to 0. Each instruction's final word carries a zero successor, so the machine returns to dispatch when the instruction ends. A halt request replaces the opcode with 0 at dispatch time.

The store sits outside the block and has a synchronous read port. The sequencer presents the read address before a clock edge. At that edge the microaddress register and the store's output register take the same address. The word on the store's data input is therefore always the word at the current microaddress.

Top module: `usq_sequencer`

## Requirements
- R1: While `rst` is high, `cs_addr` is 0. After a clock edge with `rst` high, `dbg_uaddr` is 0.
- R2: When the successor field of the current word is nonzero, the next microaddress equals that field. The successor field is bits [AW+CW-1:CW] of `cs_rdata`.
- R3: When the successor field is zero and `halt_req` is low, the next microaddress is `opcode`, zero-extended to AW bits.
- R4: When the successor field is zero and `halt_req` is high, the next microaddress is 0.
- R5: `halt_req` has no effect on the next microaddress while the successor field is nonzero.
- R6: `ctrl` equals the control field, bits [CW-1:0], of the store word at `dbg_uaddr`.
- R7: Outside reset, the `cs_addr` value presented before a clock edge is the value `dbg_uaddr` takes at that edge.
- R8: `opcode` has no effect on the next microaddress while the successor field is nonzero.
- R9: Opcode 0 with a zero successor field dispatches to the HALT entry at address 0. The sequencer stays there as long as opcode 0 is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPW | Instruction-register opcode, used as the dispatch address |
| halt_req | input | 1 | Forces dispatch to address 0 |
| cs_addr | output | AW | Control-store read address for the next edge |
| cs_rdata | input | AW+CW | Store word at the current microaddress: successor field on top, control field below |
| ctrl | output | CW | Control field of the current microword |
| dbg_uaddr | output | AW | Current microaddress |

## Verification
Two functions can fall in the same cycle: the halt request and successor chaining. The halt request is raised on a fixed cadence that lands both inside multi-word instructions and on their final words. In the first case the bench expects the chain to continue untouched. In the second it expects a jump to address 0. A bench model of the store predicts every address step from the stored successor fields, so opcode changes in the middle of an instruction are also judged as having no effect.

// File: rtl/usq_pkg.sv
package usq_pkg;
  typedef enum logic [1:0] {
    SRC_NEXT   = 2'd0,
    SRC_OPCODE = 2'd1,
    SRC_HALT   = 2'd2
  } usq_src_e;
endpackage

// File: rtl/usq_zero_det.sv
module usq_zero_det #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] next_f,
  output logic          is_zero
);
  assign is_zero = ~|next_f;
endmodule

// File: rtl/usq_addr_sel.sv
module usq_addr_sel
  import usq_pkg::*;
#(
  parameter int AW  = 6,
  parameter int OPW = 4
) (
  input  logic [AW-1:0]  next_f,
  input  logic           nxt_zero,
  input  logic           halt_req,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  sel_addr,
  output usq_src_e       sel_src
);
  // opcode value is the entry address in the dispatch region
  function automatic logic [AW-1:0] widen_op(input logic [OPW-1:0] op);
    logic [AW-1:0] w;
    w = '0;
    w[OPW-1:0] = op;
    return w;
  endfunction

  always_comb begin
    if (!nxt_zero) begin
      sel_src  = SRC_NEXT;
      sel_addr = next_f;
    end else if (halt_req) begin
      sel_src  = SRC_HALT;
      sel_addr = '0;
    end else begin
      sel_src  = SRC_OPCODE;
      sel_addr = widen_op(opcode);
    end
  end
endmodule

// File: rtl/usq_uar.sv
module usq_uar #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
  import usq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 12,
  parameter int OPW   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int WW   = AW + CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           halt_req,
  output logic [AW-1:0]  cs_addr,
  input  logic [WW-1:0]  cs_rdata,
  output logic [CW-1:0]  ctrl,
  output logic [AW-1:0]  dbg_uaddr
);
  logic [AW-1:0] next_f;
  logic          nxt_zero;
  logic [AW-1:0] sel_addr;
  usq_src_e      sel_src;
  logic [AW-1:0] uaddr;

  assign next_f = cs_rdata[WW-1:CW];
  assign ctrl   = cs_rdata[CW-1:0];

  usq_zero_det #(.AW(AW)) u_zdet (
    .next_f  (next_f),
    .is_zero (nxt_zero)
  );

  usq_addr_sel #(.AW(AW), .OPW(OPW)) u_sel (
    .next_f   (next_f),
    .nxt_zero (nxt_zero),
    .halt_req (halt_req),
    .opcode   (opcode),
    .sel_addr (sel_addr),
    .sel_src  (sel_src)
  );

  assign cs_addr = rst ? '0 : sel_addr;

  usq_uar #(.AW(AW)) u_uar (
    .clk (clk),
    .rst (rst),
    .d   (cs_addr),
    .q   (uaddr)
  );

  assign dbg_uaddr = uaddr;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (uaddr == '0)); // R1
  AST_FOLLOW_NEXT: assert property (@(posedge clk) disable iff (rst)
    (next_f != '0) |=> (uaddr == $past(next_f))); // R2
  AST_DISPATCH_OP: assert property (@(posedge clk) disable iff (rst)
    (nxt_zero && !halt_req) |=> (uaddr[OPW-1:0] == $past(opcode))); // R3
  AST_HALT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (nxt_zero && halt_req) |=> (uaddr == '0)); // R4
  AST_NEXT_WINS: assert property (@(posedge clk) disable iff (rst)
    (!nxt_zero) |-> (sel_src == SRC_NEXT)); // R5
  AST_ADDR_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (uaddr == $past(cs_addr))); // R7
endmodule

// File: tb/tb_usq_sequencer.sv
`timescale 1ns/100ps
module tb_usq_sequencer;
  localparam int DEPTH = 64;
  localparam int CW    = 12;
  localparam int OPW   = 4;
  localparam int AW    = 6;
  localparam int WW    = AW + CW;
  localparam int NOPS  = 1 << OPW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [OPW-1:0] opcode = '0;
  logic           halt_req = 1'b0;
  logic [AW-1:0]  cs_addr;
  logic [WW-1:0]  cs_rdata;
  logic [CW-1:0]  ctrl;
  logic [AW-1:0]  dbg_uaddr;

  logic [WW-1:0] mem [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_cur;
  int exp_nxt;

  always #2.5 clk = ~clk;

  usq_sequencer #(.DEPTH(DEPTH), .CW(CW), .OPW(OPW)) dut (
    .clk(clk), .rst(rst), .opcode(opcode), .halt_req(halt_req),
    .cs_addr(cs_addr), .cs_rdata(cs_rdata), .ctrl(ctrl), .dbg_uaddr(dbg_uaddr)
  );

  // synchronous-read control store model
  always_ff @(posedge clk) cs_rdata <= mem[cs_addr];

  function automatic int nf_of(input int a);
    return int'(mem[a][WW-1:CW]);
  endfunction

  function automatic int cf_of(input int a);
    return (a * 37 + 5) % (1 << CW);
  endfunction

  function automatic logic [WW-1:0] mk(input int a, input int nxt);
    logic [WW-1:0] w;
    w[WW-1:CW] = AW'(nxt);
    w[CW-1:0]  = CW'(cf_of(a));
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    opcode = OPW'(5);
    halt_req = 1'b0;
    #1;
    check(cs_addr == '0, "R1 cs_addr in reset", int'(cs_addr), 0);
    @(negedge clk);
    @(negedge clk);
    check(dbg_uaddr == '0, "R1 uaddr after reset", int'(dbg_uaddr), 0);
    check(ctrl == CW'(cf_of(0)), "R6 ctrl after reset", int'(ctrl), cf_of(0));
    rst = 1'b0;
    exp_cur = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // store image: entry of opcode k at address k, tail words in region above
    for (int a = 0; a < DEPTH; a++) mem[a] = mk(a, 0);
    for (int k = 1; k < NOPS; k++) begin
      int len;
      int base;
      len  = (k % 4) + 1;
      base = NOPS + 3 * (k - 1);
      if (len == 1) mem[k] = mk(k, 0);
      else begin
        mem[k] = mk(k, base);
        for (int j = 0; j < len - 1; j++)
          mem[base + j] = mk(base + j, (j == len - 2) ? 0 : base + j + 1);
      end
    end

    do_reset();
    for (int i = 0; i < 900; i++) begin
      string tag;
      int nf;
      if (i % 300 == 299) do_reset();
      // drive on the falling edge
      if (i >= 40 && i < 48) opcode = '0;
      else opcode = OPW'((i * 7 + 3) % NOPS);
      halt_req = (i % 9 == 4);
      #1;
      nf = nf_of(exp_cur);
      if (nf != 0) begin
        exp_nxt = nf;
        tag = halt_req ? "R5 halt ignored mid-chain" : "R8 R2 follow successor";
      end else if (halt_req) begin
        exp_nxt = 0;
        tag = "R4 halt dispatch";
      end else begin
        exp_nxt = int'(opcode);
        tag = (opcode == '0) ? "R9 stay at HALT" : "R3 opcode dispatch";
      end
      check(cs_addr == AW'(exp_nxt), "R7 read address", int'(cs_addr), exp_nxt);
      exp_cur = exp_nxt;
      @(negedge clk);
      check(dbg_uaddr == AW'(exp_cur), tag, int'(dbg_uaddr), exp_cur);
      check(ctrl == CW'(cf_of(exp_cur)), "R6 control field", int'(ctrl), cf_of(exp_cur));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule